// File: doc/BRIEF.md
# Single-Precision Floating-Point Adder

This block adds or subtracts two 32-bit binary floating-point numbers. Each word has a sign bit, an 8-bit exponent with a bias of 127, and a 23-bit fraction. A normal number has the value (-1)^sign × 1.fraction × 2^(exponent-127). The hidden leading one is put back before any arithmetic.

The work runs through four registered stages:
- unpack and align, where the significand with the smaller exponent is shifted right and guard, round and sticky bits are kept;
- signed significand add;
- normalize, with a check of the lower exponent bound;
- round to nearest even, then renormalize and check for overflow.

A new operation can be accepted every clock cycle.

Special encodings are resolved in the first stage and carried down the pipe:
- any NaN gives the quiet NaN;
- opposing infinities give the quiet NaN;
- an infinity with a finite value gives that infinity;
- exponent code 0 counts as zero.

A result below the normal range is flushed to a signed zero and flagged. A result above the range becomes a signed infinity and is flagged.

Top module: `fp32_add_pipe`

## Requirements
- R1: An operation presented with `in_valid_i` high at a rising edge produces `out_valid_o` high, with its result, after exactly four rising edges. One operation can be accepted on every cycle, and `out_valid_o` is low when nothing was issued four edges earlier.
- R2: For finite normal operands, `result_o` is the exact sum rounded to nearest, ties to even, in the format sign bit 31, exponent bits 30:23, fraction bits 22:0.
- R3: When `sub_i` is 1 the sign of `op_b_i` is inverted before the add, so the block computes a − b.
- R4: If the rounded exponent code reaches 255, the result is an infinity with the result sign (exponent 255, fraction 0), `overflow_o` is 1 and `underflow_o` is 0.
- R5: A nonzero normalized result whose exponent code falls below 1 is replaced by a zero carrying the result sign, with `underflow_o` 1 and `overflow_o` 0.
- R6: An operand with exponent code 0 is treated as zero, whatever its fraction. x + 0 returns x unchanged. An exact zero sum is +0, except that two zeros of the same effective sign give a zero of that sign.
- R7: If either operand has exponent 255 and a nonzero fraction, the result is 0x7FC00000 with both flags 0.
- R8: Infinities of opposite effective sign give 0x7FC00000. An infinity combined with a finite value, or with an infinity of the same effective sign, returns that infinity. Both flags are 0 in all these cases.
- R9: While `rst_ni` is low and right after it rises, `out_valid_o`, `result_o`, `overflow_o` and `underflow_o` are all 0.
- R10: When rounding carries out of the 24-bit significand, the significand is renormalized and the exponent rises by one. An example is 0x3FFFFFFF + 0x33800000 = 0x40000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Operands are valid this cycle |
| op_a_i | input | 32 | First operand |
| op_b_i | input | 32 | Second operand |
| sub_i | input | 1 | 1 computes a − b, 0 computes a + b |
| out_valid_o | output | 1 | Result valid |
| result_o | output | 32 | Rounded result |
| overflow_o | output | 1 | Result overflowed to infinity |
| underflow_o | output | 1 | Result was flushed to zero |

## Verification
Wrong internal state shows up at the ports exactly four cycles after the operation that met it. Each in-flight operation carries its own state through the stages, so there is no state that lasts from one operation to the next.

Each kind of fault has its own signature:
- A bad alignment shift or a lost sticky bit appears as a result off by one unit in the last place. This is most visible on ties and on large exponent gaps.
- A bad normalization shift corrupts the exponent field.
- Misrouted special flags show up as a wrong NaN or infinity code, or as a raised flag on an ordinary result.

A behavioural model in the bench works with wide exact integers. It is compared against the outputs on every cycle, so any fault is seen on the first operation that exercises it.

// File: rtl/fadd_pkg.sv
package fadd_pkg;
  localparam int unsigned EXP_W   = 8;
  localparam int unsigned FRAC_W  = 23;
  localparam int unsigned WORD_W  = 1 + EXP_W + FRAC_W;
  localparam int unsigned MAN_W   = FRAC_W + 1;
  localparam int unsigned GRS_W   = 3;
  localparam int unsigned EXT_W   = MAN_W + GRS_W;
  localparam int unsigned SUM_W   = EXT_W + 1;
  localparam int unsigned SEXP_W  = EXP_W + 2;
  localparam int unsigned LZ_W    = $clog2(EXT_W);
  localparam logic [EXP_W-1:0]  EXP_MAX = '1;
  localparam logic [WORD_W-1:0] QNAN    = {1'b0, EXP_MAX, 1'b1, {(FRAC_W-1){1'b0}}};

  typedef struct packed {
    logic              spec;
    logic [WORD_W-1:0] spec_res;
    logic              sl;
    logic              ss;
    logic [EXP_W-1:0]  exp;
    logic [EXT_W-1:0]  ml;
    logic [EXT_W-1:0]  ms;
  } align_t;

  typedef struct packed {
    logic              spec;
    logic [WORD_W-1:0] spec_res;
    logic              sign;
    logic [EXP_W-1:0]  exp;
    logic [SUM_W-1:0]  sum;
  } sum_t;

  typedef struct packed {
    logic              spec;
    logic [WORD_W-1:0] spec_res;
    logic              sign;
    logic              zero;
    logic              unf;
    logic [SEXP_W-1:0] exp;
    logic [EXT_W-1:0]  man;
  } norm_t;

  function automatic logic [LZ_W-1:0] lead_zeros(input logic [EXT_W-1:0] v);
    logic [LZ_W-1:0] n;
    logic            hit;
    n   = '0;
    hit = 1'b0;
    for (int i = EXT_W - 1; i >= 0; i--) begin
      if (!hit && v[i]) hit = 1'b1;
      else if (!hit) n = n + 1'b1;
    end
    return n;
  endfunction
endpackage

// File: rtl/fadd_align.sv
module fadd_align
  import fadd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [WORD_W-1:0] a_i,
  input  logic [WORD_W-1:0] b_i,
  input  logic              sub_i,
  output logic              valid_o,
  output align_t            q_o
);
  logic              sa, sb, a_nan, b_nan, a_inf, b_inf, swap, st;
  logic [EXP_W-1:0]  ea, eb, el, es, diff;
  logic [FRAC_W-1:0] fa, fb;
  logic [MAN_W-1:0]  ma, mb, m_l, m_s;
  logic [EXT_W-1:0]  ext, sh;
  align_t            d;

  always_comb begin
    sa    = a_i[WORD_W-1];
    sb    = b_i[WORD_W-1] ^ sub_i;  // subtract = add with flipped sign
    ea    = a_i[WORD_W-2 -: EXP_W];
    eb    = b_i[WORD_W-2 -: EXP_W];
    fa    = a_i[FRAC_W-1:0];
    fb    = b_i[FRAC_W-1:0];
    a_nan = (ea == EXP_MAX) && (fa != '0);
    b_nan = (eb == EXP_MAX) && (fb != '0);
    a_inf = (ea == EXP_MAX) && (fa == '0);
    b_inf = (eb == EXP_MAX) && (fb == '0);
    ma    = (ea == '0) ? '0 : {1'b1, fa};
    mb    = (eb == '0) ? '0 : {1'b1, fb};
    swap  = eb > ea;
    el    = swap ? eb : ea;
    es    = swap ? ea : eb;
    m_l   = swap ? mb : ma;
    m_s   = swap ? ma : mb;
    diff  = el - es;
    ext   = {m_s, {GRS_W{1'b0}}};
    if (diff >= EXP_W'(EXT_W)) begin
      sh = '0;
      st = |m_s;
    end else begin
      sh = ext >> diff;
      st = |(ext & ~({EXT_W{1'b1}} << diff));
    end
    d.spec = a_nan | b_nan | a_inf | b_inf;
    if (a_nan || b_nan || (a_inf && b_inf && (sa != sb))) d.spec_res = QNAN;
    else if (a_inf) d.spec_res = {sa, EXP_MAX, {FRAC_W{1'b0}}};
    else            d.spec_res = {sb, EXP_MAX, {FRAC_W{1'b0}}};
    d.sl  = swap ? sb : sa;
    d.ss  = swap ? sa : sb;
    d.exp = el;
    d.ml  = {m_l, {GRS_W{1'b0}}};
    d.ms  = sh | EXT_W'(st);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      q_o     <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) q_o <= d;
    end
  end

  assert_nan_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (a_nan || b_nan)) |=> (valid_o && q_o.spec && q_o.spec_res == QNAN));

  assert_align_order_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !q_o.spec && (q_o.ml == '0)) |-> (q_o.ms == '0));
endmodule

// File: rtl/fadd_sum.sv
module fadd_sum
  import fadd_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   valid_i,
  input  align_t d_i,
  output logic   valid_o,
  output sum_t   q_o
);
  logic eff_sub;
  sum_t d;

  always_comb begin
    eff_sub    = d_i.sl ^ d_i.ss;
    d.spec     = d_i.spec;
    d.spec_res = d_i.spec_res;
    d.exp      = d_i.exp;
    if (!eff_sub) begin
      d.sum  = {1'b0, d_i.ml} + {1'b0, d_i.ms};
      d.sign = d_i.sl;
    end else if (d_i.ml >= d_i.ms) begin
      d.sum  = {1'b0, d_i.ml - d_i.ms};
      d.sign = d_i.sl;
    end else begin
      d.sum  = {1'b0, d_i.ms - d_i.ml};
      d.sign = d_i.ss;
    end
    // exact cancellation gives +0; like-signed zeros keep their sign
    if (d.sum == '0) d.sign = eff_sub ? 1'b0 : d_i.sl;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      q_o     <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) q_o <= d;
    end
  end

  assert_cancel_plus_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !d_i.spec && (d_i.sl != d_i.ss) && (d_i.ml == d_i.ms))
    |=> (valid_o && q_o.sum == '0 && !q_o.sign));
endmodule

// File: rtl/fadd_norm.sv
module fadd_norm
  import fadd_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  valid_i,
  input  sum_t  d_i,
  output logic  valid_o,
  output norm_t q_o
);
  logic [LZ_W-1:0] lz;
  norm_t           d;

  always_comb begin
    lz         = lead_zeros(d_i.sum[EXT_W-1:0]);
    d.spec     = d_i.spec;
    d.spec_res = d_i.spec_res;
    d.sign     = d_i.sign;
    d.zero     = (d_i.sum == '0);
    if (d_i.sum[SUM_W-1]) begin
      d.man = d_i.sum[SUM_W-1:1] | EXT_W'(d_i.sum[0]);
      d.exp = SEXP_W'(d_i.exp) + SEXP_W'(1);
    end else begin
      d.man = d_i.sum[EXT_W-1:0] << lz;
      d.exp = SEXP_W'(d_i.exp) - SEXP_W'(lz);
    end
    // exponent code below 1 (zero or negative) is out of range
    d.unf = !d.zero && (d.exp[SEXP_W-1] || (d.exp == '0));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      q_o     <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) q_o <= d;
    end
  end

  assert_norm_lead_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !q_o.spec && !q_o.zero) |-> q_o.man[EXT_W-1]);
endmodule

// File: rtl/fadd_round.sv
module fadd_round
  import fadd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  norm_t             d_i,
  output logic              valid_o,
  output logic [WORD_W-1:0] res_o,
  output logic              ovf_o,
  output logic              unf_o
);
  logic              inc, ovf_c;
  logic [MAN_W:0]    rm;
  logic [FRAC_W-1:0] frac;
  logic [SEXP_W-1:0] er;
  logic [WORD_W-1:0] res_d;
  logic              ovf_d, unf_d;

  always_comb begin
    inc = d_i.man[GRS_W-1] & (d_i.man[GRS_W] | (|d_i.man[GRS_W-2:0]));
    rm  = {1'b0, d_i.man[EXT_W-1:GRS_W]} + (MAN_W+1)'(inc);
    if (rm[MAN_W]) begin
      frac = rm[FRAC_W:1];
      er   = d_i.exp + SEXP_W'(1);
    end else begin
      frac = rm[FRAC_W-1:0];
      er   = d_i.exp;
    end
    ovf_c = er >= SEXP_W'(EXP_MAX);
    ovf_d = 1'b0;
    unf_d = 1'b0;
    if (d_i.spec) begin
      res_d = d_i.spec_res;
    end else if (d_i.zero) begin
      res_d = {d_i.sign, {(WORD_W-1){1'b0}}};
    end else if (d_i.unf) begin
      res_d = {d_i.sign, {(WORD_W-1){1'b0}}};
      unf_d = 1'b1;
    end else if (ovf_c) begin
      res_d = {d_i.sign, EXP_MAX, {FRAC_W{1'b0}}};
      ovf_d = 1'b1;
    end else begin
      res_d = {d_i.sign, er[EXP_W-1:0], frac};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      res_o   <= '0;
      ovf_o   <= 1'b0;
      unf_o   <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        res_o <= res_d;
        ovf_o <= ovf_d;
        unf_o <= unf_d;
      end
    end
  end

  assert_round_carry_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !d_i.spec && !d_i.zero && !d_i.unf && (d_i.man[EXT_W-1:GRS_W] == '1) && inc
     && (d_i.exp < SEXP_W'(EXP_MAX - 1)))
    |=> (res_o[FRAC_W-1:0] == '0 && res_o[WORD_W-2 -: EXP_W] == EXP_W'($past(d_i.exp) + 1)));
endmodule

// File: rtl/fp32_add_pipe.sv
module fp32_add_pipe
  import fadd_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        in_valid_i,
  input  logic [31:0] op_a_i,
  input  logic [31:0] op_b_i,
  input  logic        sub_i,
  output logic        out_valid_o,
  output logic [31:0] result_o,
  output logic        overflow_o,
  output logic        underflow_o
);
  logic   v1, v2, v3;
  align_t s1;
  sum_t   s2;
  norm_t  s3;

  fadd_align u_align (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(in_valid_i),
    .a_i(op_a_i), .b_i(op_b_i), .sub_i(sub_i), .valid_o(v1), .q_o(s1));

  fadd_sum u_sum (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(v1), .d_i(s1), .valid_o(v2), .q_o(s2));

  fadd_norm u_norm (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(v2), .d_i(s2), .valid_o(v3), .q_o(s3));

  fadd_round u_round (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(v3), .d_i(s3), .valid_o(out_valid_o),
    .res_o(result_o), .ovf_o(overflow_o), .unf_o(underflow_o));

  logic a_inf_in, b_finite_in;
  assign a_inf_in    = (op_a_i[30:23] == EXP_MAX) && (op_a_i[22:0] == '0);
  assign b_finite_in = (op_b_i[30:23] != EXP_MAX);

  assert_latency_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |-> ##4 out_valid_o);

  assert_ovf_inf_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && overflow_o) |-> (result_o[30:0] == {EXP_MAX, {FRAC_W{1'b0}}} && !underflow_o));

  assert_unf_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && underflow_o) |-> (result_o[30:0] == '0 && !overflow_o));

  assert_inf_pass_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && a_inf_in && b_finite_in) |-> ##4 (result_o == $past(op_a_i, 4) && !overflow_o));
endmodule

// File: tb/sim_fp32_add_pipe.sv
module sim_fp32_add_pipe;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] op_a = '0, op_b = '0;
  logic        sub = 1'b0;
  string       tag_in = "R2";
  logic        out_valid, ovf, unf;
  logic [31:0] result;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  fp32_add_pipe u0 (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .op_a_i(op_a), .op_b_i(op_b),
    .sub_i(sub), .out_valid_o(out_valid), .result_o(result), .overflow_o(ovf), .underflow_o(unf));

  // exact reference: values as wide integers in units of 2^-150
  function automatic logic [33:0] ref_add(input logic [31:0] a, input logic [31:0] b, input logic s);
    logic sa, sb, sg, inc;
    int ea, eb, p, e;
    logic [22:0] fa, fb;
    logic [299:0] va, vb, mag, rem, half, one;
    logic [24:0] m;
    sa = a[31]; sb = b[31] ^ s;
    ea = int'(a[30:23]); eb = int'(b[30:23]);
    fa = a[22:0]; fb = b[22:0];
    if ((ea == 255 && fa != 0) || (eb == 255 && fb != 0)) return {2'b00, 32'h7FC00000};
    if (ea == 255 && eb == 255) return (sa == sb) ? {2'b00, sa, 8'hFF, 23'h0} : {2'b00, 32'h7FC00000};
    if (ea == 255) return {2'b00, sa, 8'hFF, 23'h0};
    if (eb == 255) return {2'b00, sb, 8'hFF, 23'h0};
    va = (ea == 0) ? '0 : (300'({1'b1, fa}) << ea);
    vb = (eb == 0) ? '0 : (300'({1'b1, fb}) << eb);
    if (sa == sb) begin mag = va + vb; sg = sa; end
    else if (va >= vb) begin mag = va - vb; sg = sa; end
    else begin mag = vb - va; sg = sb; end
    if (mag == 0) return {2'b00, (sa == sb) ? sa : 1'b0, 31'h0};
    p = 0;
    for (int i = 0; i < 300; i++) if (mag[i]) p = i;
    e = p - 23;
    if (e < 1) return {2'b01, sg, 31'h0};
    one  = 300'd1;
    m    = 25'(mag >> (p - 23));
    rem  = mag & ((one << (p - 23)) - one);
    half = one << (p - 24);
    inc  = (rem > half) || (rem == half && m[0]);
    m    = m + 25'(inc);
    if (m[24]) begin m = m >> 1; e++; end
    if (e >= 255) return {2'b10, sg, 8'hFF, 23'h0};
    return {2'b00, sg, 8'(e), m[22:0]};
  endfunction

  logic        mv[1:4];
  logic [33:0] me[1:4];
  string       mt[1:4];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 1; i <= 4; i++) begin mv[i] <= 1'b0; me[i] <= '0; mt[i] <= "R1"; end
    end else begin
      mv[1] <= in_valid;
      me[1] <= ref_add(op_a, op_b, sub);
      mt[1] <= tag_in;
      for (int i = 2; i <= 4; i++) begin mv[i] <= mv[i-1]; me[i] <= me[i-1]; mt[i] <= mt[i-1]; end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (out_valid !== mv[4]) begin
        fails++;
        $display("FAIL R1 out_valid actual %0b expected %0b", out_valid, mv[4]);
      end
      if (mv[4]) begin
        checks++;
        if ({ovf, unf, result} !== me[4]) begin
          fails++;
          $display("FAIL %s ovf/unf/result actual %0b/%0b/%08h expected %0b/%0b/%08h",
                   mt[4], ovf, unf, result, me[4][33], me[4][32], me[4][31:0]);
        end
      end
    end
  end

  task automatic put(input logic [31:0] a, input logic [31:0] b, input logic s, input string t);
    @(negedge clk);
    in_valid = 1'b1; op_a = a; op_b = b; sub = s; tag_in = t;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  task automatic finish_run;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;  // R9 during reset
    if ({out_valid, ovf, unf, result} !== 35'h0) begin
      fails++;
      $display("FAIL R9 in reset actual %0b/%0b/%0b/%08h expected 0", out_valid, ovf, unf, result);
    end
    rst_n = 1'b1;
    @(negedge clk);
    checks++;  // R9 after release
    if ({out_valid, ovf, unf, result} !== 35'h0) begin
      fails++;
      $display("FAIL R9 after reset actual %0b/%0b/%0b/%08h expected 0", out_valid, ovf, unf, result);
    end
    // R2 directed
    put(32'h3F800000, 32'h3F800000, 1'b0, "R2");
    put(32'h3FC00000, 32'h40100000, 1'b0, "R2");
    put(32'h3F800000, 32'h33800000, 1'b0, "R2");   // tie, even kept
    put(32'h3F800001, 32'h33800000, 1'b0, "R2");   // tie, odd rounds up
    put(32'h3F800000, 32'h00800000, 1'b1, "R2");   // huge exponent gap
    idle(2);
    // R3 subtraction
    put(32'h40A00000, 32'h40400000, 1'b1, "R3");
    put(32'h40A00000, 32'hC0400000, 1'b1, "R3");
    put(32'h40400000, 32'h40A00000, 1'b1, "R3");
    // R4 overflow
    put(32'h7F7FFFFF, 32'h7F7FFFFF, 1'b0, "R4");
    put(32'hFF7FFFFF, 32'h7F7FFFFF, 1'b1, "R4");
    put(32'h7F7FFFFF, 32'h73000000, 1'b0, "R4");   // rounding tips into overflow
    // R5 underflow
    put(32'h00800001, 32'h00800000, 1'b1, "R5");
    put(32'h80C00000, 32'h80800000, 1'b1, "R5");
    // R6 zeros
    put(32'h00000005, 32'h3F800000, 1'b0, "R6");
    put(32'h80000000, 32'h80000000, 1'b0, "R6");
    put(32'h3F800000, 32'h3F800000, 1'b1, "R6");
    put(32'h80000000, 32'h00000000, 1'b0, "R6");
    put(32'h80000000, 32'h00000000, 1'b1, "R6");
    put(32'hC1200000, 32'h007FFFFF, 1'b0, "R6");
    // R7 NaN
    put(32'h7FC00001, 32'h3F800000, 1'b0, "R7");
    put(32'h3F800000, 32'hFF800001, 1'b1, "R7");
    // R8 infinities
    put(32'h7F800000, 32'h7F800000, 1'b1, "R8");
    put(32'h7F800000, 32'hFF800000, 1'b0, "R8");
    put(32'h7F800000, 32'h3F800000, 1'b0, "R8");
    put(32'hFF800000, 32'h7F800000, 1'b1, "R8");
    put(32'h12345678, 32'hFF800000, 1'b1, "R8");
    // R10 rounding carry
    put(32'h3FFFFFFF, 32'h33800000, 1'b0, "R10");
    put(32'hBFFFFFFF, 32'hB4000000, 1'b0, "R10");
    idle(3);
    // R1 back-to-back random traffic, R2 results
    for (int i = 0; i < 400; i++) begin
      logic [31:0] a, b;
      a = $urandom;
      b = $urandom;
      if (i % 3 != 0) b[30:23] = 8'(int'(a[30:23]) + ($urandom % 30) - 15);
      if (i % 50 == 7) idle(1);
      put(a, b, 1'(($urandom) & 1), "R2");
    end
    idle(8);
    finish_run();
  end
endmodule